// File: doc/BRIEF.md
# Task Switch Control Sequencer

This block decides whether a requested change of task may proceed and, if it may, walks the change through its steps. A request carries its kind (direct descriptor call or jump, call or jump through a task gate, software interrupt, hardware interrupt, exception, or interrupt return with the nested-task flag set). It also carries the current and requested privilege levels, the fields of the gate entry and of the task state descriptor, and the selector of the task to enter. Only the segment selector of a far target is used, and any offset is never presented to the block. The target is the call selector, the selector held in the gate, or the back-link selector of the current state segment, depending on the kind.

Once a request is accepted, the block copies the selector and the descriptor into staging registers. It then applies the privilege rule for the request path. If the rule passes, it asks memory to save the current task state and afterwards to load the new task state, using a request/acknowledge handshake. The task register, with its visible selector and hidden descriptor, is committed only when the load has been acknowledged. A refused request raises a one-cycle fault and leaves the task register untouched. A busy output holds off further requests until the sequencer is idle again.

Top module: `taskSwitchSeq`

## Requirements
- R1: After reset, trSel and trDesc are zero and busy, memReq, done and fault are low.
- R2: The reqKind codes are 0 direct descriptor call or jump, 1 gate call or jump, 2 software interrupt, 3 hardware interrupt, 4 exception, and 5 nested-task return. A direct request (kind 0) switches only when cpl <= tssDpl, taken as unsigned 2-bit values with 0 the most privileged.
- R3: A gate request (kind 1) switches only when max(cpl, rpl) <= gateDpl. For this kind, tssDpl has no effect on the outcome.
- R4: A software interrupt (kind 2) switches only when gateOk is 1 and cpl <= gateDpl.
- R5: A hardware interrupt (kind 3) or an exception (kind 4) switches whenever gateOk is 1, whatever the privilege levels are.
- R6: A nested-task return (kind 5) switches to tgtSel with no privilege check, whatever the value of gateOk.
- R7: A request is refused when tssOk is 0, or when tgtSel bit 2 is 1 (the selector points into a local table), or when a kind from 1 to 4 has gateOk at 0.
- R8: On a refused request, fault is high for exactly one cycle, in the fourth cycle after the accepting clock edge. busy is low in the cycle after that, and trSel and trDesc keep their earlier values.
- R9: On an allowed request, memReq rises in the fourth cycle after the accepting edge with memWrite=1 and memSel equal to the current trSel (save). After that request is acknowledged, memReq stays high with memWrite=0 and memSel equal to the new selector (load). Each request stays high, with memWrite unchanged, until memAck is seen.
- R10: In the cycle after the load acknowledge, done is high for one cycle and trSel and trDesc show the new selector and descriptor. trSel changes at no other time.
- R11: busy is high from the cycle after acceptance until the sequencer returns to idle. While busy is high, reqValid has no effect. A request with reqKind 6 or 7 is never accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqKind | input | 3 | Request kind code |
| cpl | input | 2 | Current privilege level |
| rpl | input | 2 | Requested privilege level of the selector |
| gateOk | input | 1 | Gate entry is a task gate |
| gateDpl | input | 2 | Privilege level of the gate |
| tssOk | input | 1 | Target descriptor is a task state descriptor |
| tssDpl | input | 2 | Privilege level of the target descriptor |
| tgtSel | input | 16 | Selector of the task to enter |
| descWord | input | 64 | Target descriptor contents |
| memAck | input | 1 | Memory acknowledge |
| memReq | output | 1 | Memory request |
| memWrite | output | 1 | 1 = save current state, 0 = load new state |
| memSel | output | 16 | Selector of the state segment being accessed |
| trSel | output | 16 | Visible task register selector |
| trDesc | output | 64 | Hidden task register descriptor |
| busy | output | 1 | Switch in progress |
| done | output | 1 | One-cycle pulse when a switch completes |
| fault | output | 1 | One-cycle pulse when a switch is refused |

## Verification
The assertions assume that memAck is raised only while memReq is high and is dropped again before the next request is issued. They also assume that rstN is low from time zero until after the first clock edge. The bench raises the acknowledge on a falling edge only when it has seen memReq and clears it one cycle later. It holds reset across the first edges and adds a variable delay before each acknowledge, so that the hold-until-acknowledge rule is exercised. Request fields are held stable from the cycle a request is presented until it is accepted.

// File: rtl/tsw_pkg.sv
package tsw_pkg;

  localparam int KIND_W = 3;

  typedef enum logic [KIND_W-1:0] {
    K_DIRECT = 3'd0,
    K_GATE   = 3'd1,
    K_SWINT  = 3'd2,
    K_HWINT  = 3'd3,
    K_EXC    = 3'd4,
    K_NTRET  = 3'd5
  } reqKind_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SELLD,
    S_DESCLD,
    S_CHECK,
    S_SAVE,
    S_LOAD,
    S_DONE,
    S_FAULT
  } seqState_e;

  typedef struct packed {
    logic latchReq;
    logic stageSel;
    logic stageDesc;
    logic commit;
  } seqStrobe_t;

endpackage

// File: rtl/tsw_dpath.sv
module tsw_dpath
  import tsw_pkg::*;
#(
  parameter int SEL_W  = 16,
  parameter int DESC_W = 64,
  parameter int PL_W   = 2,
  parameter int TI_BIT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        stb,
  input  logic [KIND_W-1:0] reqKind,
  input  logic [PL_W-1:0]   cpl,
  input  logic [PL_W-1:0]   rpl,
  input  logic              gateOk,
  input  logic [PL_W-1:0]   gateDpl,
  input  logic              tssOk,
  input  logic [PL_W-1:0]   tssDpl,
  input  logic [SEL_W-1:0]  tgtSel,
  input  logic [DESC_W-1:0] descWord,
  output logic              checkPass,
  output logic [SEL_W-1:0]  pendSel,
  output logic [SEL_W-1:0]  trSel,
  output logic [DESC_W-1:0] trDesc
);

  logic [KIND_W-1:0] kindQ;
  logic [PL_W-1:0]   cplQ, rplQ, gateDplQ, tssDplQ;
  logic              gateOkQ, tssOkQ;
  logic [SEL_W-1:0]  selHold;
  logic [DESC_W-1:0] descHold, pendDesc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      kindQ    <= '0;
      cplQ     <= '0;
      rplQ     <= '0;
      gateDplQ <= '0;
      tssDplQ  <= '0;
      gateOkQ  <= 1'b0;
      tssOkQ   <= 1'b0;
      selHold  <= '0;
      descHold <= '0;
    end else if (stb.latchReq) begin
      kindQ    <= reqKind;
      cplQ     <= cpl;
      rplQ     <= rpl;
      gateDplQ <= gateDpl;
      tssDplQ  <= tssDpl;
      gateOkQ  <= gateOk;
      tssOkQ   <= tssOk;
      selHold  <= tgtSel;
      descHold <= descWord;
    end
  end

  // staging copies of the task register, committed only on success
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendSel  <= '0;
      pendDesc <= '0;
    end else begin
      if (stb.stageSel)  pendSel  <= selHold;
      if (stb.stageDesc) pendDesc <= descHold;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trSel  <= '0;
      trDesc <= '0;
    end else if (stb.commit) begin
      trSel  <= pendSel;
      trDesc <= pendDesc;
    end
  end

  // privilege rule chosen by request path
  logic [PL_W-1:0] effPl;
  logic            privOk, needGate, kindOk;

  assign effPl = (cplQ > rplQ) ? cplQ : rplQ;

  always_comb begin
    privOk   = 1'b0;
    needGate = 1'b0;
    kindOk   = 1'b1;
    unique case (kindQ)
      K_DIRECT: privOk = (cplQ <= tssDplQ);
      K_GATE:   begin privOk = (effPl <= gateDplQ); needGate = 1'b1; end
      K_SWINT:  begin privOk = (cplQ <= gateDplQ);  needGate = 1'b1; end
      K_HWINT,
      K_EXC:    begin privOk = 1'b1; needGate = 1'b1; end
      K_NTRET:  privOk = 1'b1;
      default:  kindOk = 1'b0;
    endcase
  end

  assign checkPass = kindOk & privOk & tssOkQ & ~pendSel[TI_BIT] &
                     (gateOkQ | ~needGate);

  // R10: committed descriptor moves only together with a commit strobe
  p_desc_commit_r10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(trDesc) |-> $past(stb.commit));

endmodule

// File: rtl/tsw_ctrl.sv
module tsw_ctrl
  import tsw_pkg::*;
#(
  parameter int NUM_KINDS = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [KIND_W-1:0] reqKind,
  input  logic              checkPass,
  input  logic              memAck,
  output seqStrobe_t        stb,
  output logic              memReq,
  output logic              memWrite,
  output logic              busy,
  output logic              done,
  output logic              fault
);

  seqState_e state, nextState;
  logic      accept;

  assign accept = reqValid && (state == S_IDLE) &&
                  (int'(reqKind) < NUM_KINDS);

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    unique case (state)
      S_IDLE:   if (accept) nextState = S_SELLD;
      S_SELLD:  nextState = S_DESCLD;
      S_DESCLD: nextState = S_CHECK;
      S_CHECK:  nextState = checkPass ? S_SAVE : S_FAULT;
      S_SAVE:   if (memAck) nextState = S_LOAD;
      S_LOAD:   if (memAck) nextState = S_DONE;
      S_DONE:   nextState = S_IDLE;
      S_FAULT:  nextState = S_IDLE;
      default:  nextState = S_IDLE;
    endcase
  end

  always_comb begin
    stb.latchReq  = accept;
    stb.stageSel  = (state == S_SELLD);
    stb.stageDesc = (state == S_DESCLD);
    stb.commit    = (state == S_LOAD) && memAck;
  end

  assign memReq   = (state == S_SAVE) || (state == S_LOAD);
  assign memWrite = (state == S_SAVE);
  assign busy     = (state != S_IDLE);
  assign done     = (state == S_DONE);
  assign fault    = (state == S_FAULT);

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memWrite));

  p_save_first_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memReq) |-> memWrite);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_fault_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    fault |=> !fault && !busy);

  p_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(done && fault));

endmodule

// File: rtl/taskSwitchSeq.sv
module taskSwitchSeq
  import tsw_pkg::*;
#(
  parameter int SEL_W  = 16,
  parameter int DESC_W = 64,
  parameter int PL_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [KIND_W-1:0] reqKind,
  input  logic [PL_W-1:0]   cpl,
  input  logic [PL_W-1:0]   rpl,
  input  logic              gateOk,
  input  logic [PL_W-1:0]   gateDpl,
  input  logic              tssOk,
  input  logic [PL_W-1:0]   tssDpl,
  input  logic [SEL_W-1:0]  tgtSel,
  input  logic [DESC_W-1:0] descWord,
  input  logic              memAck,
  output logic              memReq,
  output logic              memWrite,
  output logic [SEL_W-1:0]  memSel,
  output logic [SEL_W-1:0]  trSel,
  output logic [DESC_W-1:0] trDesc,
  output logic              busy,
  output logic              done,
  output logic              fault
);

  seqStrobe_t       stb;
  logic             checkPass;
  logic [SEL_W-1:0] pendSel;

  tsw_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .checkPass(checkPass), .memAck(memAck), .stb(stb),
    .memReq(memReq), .memWrite(memWrite), .busy(busy),
    .done(done), .fault(fault)
  );

  tsw_dpath #(.SEL_W(SEL_W), .DESC_W(DESC_W), .PL_W(PL_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .reqKind(reqKind),
    .cpl(cpl), .rpl(rpl), .gateOk(gateOk), .gateDpl(gateDpl),
    .tssOk(tssOk), .tssDpl(tssDpl), .tgtSel(tgtSel), .descWord(descWord),
    .checkPass(checkPass), .pendSel(pendSel), .trSel(trSel), .trDesc(trDesc)
  );

  assign memSel = memWrite ? trSel : pendSel;

  p_tr_commit_r10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(trSel) |-> done);

  p_fault_keeps_tr_r8: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> $stable(trSel) && $stable(trDesc));

endmodule

// File: tb/sim_taskSwitchSeq.sv
module sim_taskSwitchSeq;

  localparam int CLK_P = 10;

  typedef struct packed {
    logic [2:0]  kind;
    logic [1:0]  cpl;
    logic [1:0]  rpl;
    logic        gOk;
    logic [1:0]  gDpl;
    logic        tOk;
    logic [1:0]  tDpl;
    logic [15:0] sel;
    logic        pass;
    logic [3:0]  rq;
    logic [3:0]  ackDly;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{3'd0, 2'd0, 2'd0, 1'b0, 2'd0, 1'b1, 2'd0, 16'h0008, 1'b1, 4'd2, 4'd0}, // R2 equal
    '{3'd0, 2'd3, 2'd0, 1'b0, 2'd3, 1'b1, 2'd0, 16'h0010, 1'b0, 4'd2, 4'd0}, // R2 refuse
    '{3'd0, 2'd2, 2'd3, 1'b0, 2'd0, 1'b1, 2'd2, 16'h0018, 1'b1, 4'd2, 4'd3}, // R2 boundary
    '{3'd1, 2'd0, 2'd3, 1'b1, 2'd2, 1'b1, 2'd3, 16'h0020, 1'b0, 4'd3, 4'd0}, // R3 rpl dominates
    '{3'd1, 2'd1, 2'd3, 1'b1, 2'd3, 1'b1, 2'd0, 16'h0028, 1'b1, 4'd3, 4'd1}, // R3 tssDpl ignored
    '{3'd2, 2'd3, 2'd0, 1'b1, 2'd0, 1'b1, 2'd3, 16'h0030, 1'b0, 4'd4, 4'd0}, // R4 refuse
    '{3'd2, 2'd0, 2'd0, 1'b1, 2'd3, 1'b1, 2'd0, 16'h0038, 1'b1, 4'd4, 4'd2}, // R4 allow
    '{3'd2, 2'd0, 2'd0, 1'b0, 2'd3, 1'b1, 2'd3, 16'h0040, 1'b0, 4'd7, 4'd0}, // R7 not a gate
    '{3'd3, 2'd3, 2'd3, 1'b1, 2'd0, 1'b1, 2'd0, 16'h0048, 1'b1, 4'd5, 4'd0}, // R5 hw int
    '{3'd4, 2'd3, 2'd0, 1'b1, 2'd0, 1'b1, 2'd0, 16'h0050, 1'b1, 4'd5, 4'd4}, // R5 exception
    '{3'd5, 2'd3, 2'd3, 1'b0, 2'd0, 1'b1, 2'd0, 16'h0058, 1'b1, 4'd6, 4'd0}, // R6 return
    '{3'd0, 2'd0, 2'd0, 1'b0, 2'd0, 1'b1, 2'd3, 16'h0064, 1'b0, 4'd7, 4'd0}, // R7 local table
    '{3'd0, 2'd0, 2'd0, 1'b0, 2'd0, 1'b0, 2'd3, 16'h0068, 1'b0, 4'd7, 4'd0}  // R7 not tss
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [2:0]  reqKind = '0;
  logic [1:0]  cpl = '0, rpl = '0, gateDpl = '0, tssDpl = '0;
  logic        gateOk = 1'b0, tssOk = 1'b0, memAck = 1'b0;
  logic [15:0] tgtSel = '0;
  logic [63:0] descWord = '0;
  logic        memReq, memWrite, busy, done, fault;
  logic [15:0] memSel, trSel;
  logic [63:0] trDesc;

  int nChecks = 0;
  int nErrors = 0;
  logic [15:0] modelSel = '0;
  logic [63:0] modelDesc = '0;

  always #(CLK_P/2) clk = ~clk;

  taskSwitchSeq u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .cpl(cpl), .rpl(rpl), .gateOk(gateOk), .gateDpl(gateDpl),
    .tssOk(tssOk), .tssDpl(tssDpl), .tgtSel(tgtSel), .descWord(descWord),
    .memAck(memAck), .memReq(memReq), .memWrite(memWrite), .memSel(memSel),
    .trSel(trSel), .trDesc(trDesc), .busy(busy), .done(done), .fault(fault)
  );

  task automatic chk(input logic ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic present(input vec_t v, input logic [63:0] d);
    @(negedge clk);
    reqValid = 1'b1; reqKind = v.kind; cpl = v.cpl; rpl = v.rpl;
    gateOk = v.gOk; gateDpl = v.gDpl; tssOk = v.tOk; tssDpl = v.tDpl;
    tgtSel = v.sel; descWord = d;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic ackAfter(input int dly, input string tag);
    for (int k = 0; k < dly; k++) begin
      @(negedge clk);
      chk(memReq === 1'b1, tag, memReq, 1);
    end
    memAck = 1'b1;
    @(negedge clk);
    memAck = 1'b0;
  endtask

  // runs one request from presentation to return to idle
  task automatic runVec(input vec_t v, input logic [63:0] d, input string tag);
    present(v, d);
    chk(busy === 1'b1, {tag, " busy"}, busy, 1);
    repeat (3) @(negedge clk);
    if (!v.pass) begin
      chk(fault === 1'b1, {tag, " fault R8"}, fault, 1);
      @(negedge clk);
      chk(fault === 1'b0 && busy === 1'b0, {tag, " fault end R8"}, {fault, busy}, 0);
      chk(trSel === modelSel && trDesc === modelDesc, {tag, " tr kept R8"},
          trSel, modelSel);
    end else begin
      chk(fault === 1'b0, {tag, " no fault"}, fault, 0);
      chk(memReq === 1'b1 && memWrite === 1'b1 && memSel === modelSel,
          {tag, " save R9"}, {memReq, memWrite, memSel}, {2'b11, modelSel});
      ackAfter(int'(v.ackDly), {tag, " save hold R9"});
      chk(memReq === 1'b1 && memWrite === 1'b0 && memSel === v.sel,
          {tag, " load R9"}, {memReq, memWrite, memSel}, {2'b10, v.sel});
      chk(trSel === modelSel, {tag, " tr before done R10"}, trSel, modelSel);
      ackAfter(int'(v.ackDly), {tag, " load hold R9"});
      modelSel = v.sel;
      modelDesc = d;
      chk(done === 1'b1 && trSel === modelSel && trDesc === modelDesc,
          {tag, " done R10"}, {done, trSel}, {1'b1, modelSel});
      @(negedge clk);
      chk(done === 1'b0 && busy === 1'b0, {tag, " idle R10"}, {done, busy}, 0);
    end
  endtask

  initial begin
    #(CLK_P * 20000);
    nChecks++;
    nErrors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(trSel === 16'h0 && trDesc === 64'h0, "R1 tr reset", trSel, 0);
    chk({busy, memReq, done, fault} === 4'b0, "R1 outputs reset",
        {busy, memReq, done, fault}, 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [63:0] d;
      d = {VEC[i].sel, 48'hC3A5_0000_0000} ^ 64'(i * 32'h1111_0101);
      runVec(VEC[i], d, $sformatf("vec%0d R%0d", i, VEC[i].rq));
    end

    // R11 requests while busy are ignored
    begin
      vec_t a, b;
      a = VEC[0]; a.sel = 16'h0070; a.ackDly = 4'd2;
      b = VEC[0]; b.sel = 16'h0078;
      present(a, 64'hAAAA_0000_0000_0070);
      reqValid = 1'b1; tgtSel = b.sel; descWord = 64'hBBBB;
      repeat (3) @(negedge clk);
      chk(memReq === 1'b1 && memWrite === 1'b1, "R11 busy seq", memReq, 1);
      memAck = 1'b1; @(negedge clk); memAck = 1'b0;
      chk(memSel === 16'h0070, "R11 busy load sel", memSel, 16'h0070);
      memAck = 1'b1; @(negedge clk); memAck = 1'b0;
      reqValid = 1'b0;
      chk(done === 1'b1 && trSel === 16'h0070, "R11 busy ignored", trSel, 16'h0070);
      modelSel = 16'h0070; modelDesc = 64'hAAAA_0000_0000_0070;
      @(negedge clk);
    end

    // R11 undefined kinds never accepted
    for (int k = 6; k < 8; k++) begin
      @(negedge clk);
      reqValid = 1'b1; reqKind = 3'(k); tssOk = 1'b1; tgtSel = 16'h0080;
      @(negedge clk);
      reqValid = 1'b0;
      chk(busy === 1'b0, "R11 kind ignored", busy, 0);
      repeat (4) @(negedge clk);
      chk(memReq === 1'b0 && fault === 1'b0 && trSel === modelSel,
          "R11 kind no effect", trSel, modelSel);
    end

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule